// File: doc/BRIEF.md
# Same-Colour Defective Pixel Replacement Filter

This block is a streaming filter for a raster of 10-bit Bayer-pattern pixels. It treats a pixel as defective when the pixel stands out from both of its nearest same-colour neighbours in the same row. In a Bayer stream those neighbours are two positions to the left and two positions to the right. A defective pixel is replaced by the rounded-down mean of those two neighbours. Pixels that are not defective pass through unchanged.

Pixels enter with a valid strobe and with start-of-line and end-of-line markers. A pixel is accepted on every clock edge at which the strobe is high. Idle cycles stall the pipeline and lose no state. Each result leaves the block two accepted pixels after its own input, and its markers are delayed to match. A 7-bit threshold sets how far a pixel must stand out. A typical setting is 20. An enable input turns the correction off without changing the latency.

Top module: `bpr_filter`

## Requirements
- R1: When `flt_en_i` is 0 at the moment a result is formed, the output pixel equals the input pixel, with the same latency as when correction is on.
- R2: A pixel C whose same-row neighbours L (two positions earlier) and R (two positions later) satisfy C > L+T and C > R+T, where T is `flt_thr_i`, is output as floor((L+R)/2).
- R3: A pixel C with C+T < L and C+T < R is output as floor((L+R)/2).
- R4: A pixel exactly T away from a neighbour is kept. A pixel that is above one neighbour and below the other is kept.
- R5: The pixels one position away (the other colour) never influence whether a pixel is replaced.
- R6: The first two pixels of a line (counted from the pixel flagged by `px_sol_i`) and the last two (ending at the pixel flagged by `px_eol_i`) are always output unchanged.
- R7: The result for the j-th accepted pixel appears, with `px_valid_o` high, one clock after the (j+2)-th accepted pixel. `px_sol_o` and `px_eol_o` carry that pixel's own markers. Enable and threshold are taken from the cycle in which pixel j+2 is accepted.
- R8: In a cycle after which `px_valid_i` was low, `px_valid_o` is low and `px_data_o` keeps its previous value.
- R9: The threshold covers its whole range. At T=0 any strict outlier is replaced. At T=127 only differences of 128 or more count.
- R10: After reset `px_valid_o` is 0 and `px_data_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| px_valid_i | input | 1 | Input pixel strobe |
| px_data_i | input | 10 | Input pixel value |
| px_sol_i | input | 1 | Input pixel is first of its line |
| px_eol_i | input | 1 | Input pixel is last of its line |
| flt_en_i | input | 1 | Correction enable |
| flt_thr_i | input | 7 | Outlier threshold |
| px_valid_o | output | 1 | Output pixel strobe |
| px_data_o | output | 10 | Filtered pixel value |
| px_sol_o | output | 1 | Output pixel is first of its line |
| px_eol_o | output | 1 | Output pixel is last of its line |

## Verification
The result for pixel j is due one clock after pixel j+2 is accepted. At every falling edge the bench counts the inputs accepted so far. It requires exactly j+3 accepted inputs when output j appears, and it requires that the cycle just past carried an input. The expected value for pixel j is computed from the stored stream, using the enable and threshold that were driven with pixel j+2, because those are the values in force when the block forms the result. On falling edges with no output, the bench checks that the data output still holds the last value it delivered.

// File: rtl/bpr_pkg.sv
package bpr_pkg;

  // Recommended threshold setting for typical sensors.
  localparam int unsigned BPR_THR_TYPICAL = 20;

  // Outcome of the outlier test for one centre pixel.
  typedef enum logic [1:0] {
    DEC_KEEP = 2'd0,
    DEC_HIGH = 2'd1,
    DEC_LOW  = 2'd2,
    DEC_EDGE = 2'd3
  } bpr_dec_e;

endpackage

// File: rtl/bpr_window.sv
module bpr_window #(
  parameter int unsigned DW   = 10,
  parameter int unsigned DIST = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  input  logic [DW-1:0] pix_i,
  input  logic          sol_i,
  input  logic          eol_i,
  output logic [DW-1:0] lft_o,
  output logic [DW-1:0] ctr_o,
  output logic [DW-1:0] rgt_o,
  output logic          ctr_vld_o,
  output logic          ctr_sol_o,
  output logic          ctr_eol_o,
  output logic          lok_o,
  output logic          rok_o
);

  localparam int unsigned PIX_DEPTH = 2 * DIST;
  localparam int unsigned IDX_W     = $clog2(DIST + 1);
  localparam logic [IDX_W-1:0] IDX_SAT = IDX_W'(DIST);

  typedef struct packed {
    logic vld;
    logic sol;
    logic eol;
    logic lok;
  } flag_t;

  logic [PIX_DEPTH-1:0][DW-1:0] pix_q, pix_d;
  flag_t [DIST-1:0]             flg_q, flg_d;
  logic [IDX_W-1:0]             idx_q, idx_d;
  logic [IDX_W-1:0]             idx_now;
  flag_t                        flg_new;

  // In-line position of the incoming pixel, saturating at DIST
  always_comb begin
    if (sol_i)                idx_now = '0;
    else if (idx_q == IDX_SAT) idx_now = IDX_SAT;
    else                      idx_now = idx_q + 1'b1;
    flg_new.vld = 1'b1;
    flg_new.sol = sol_i;
    flg_new.eol = eol_i;
    flg_new.lok = (idx_now == IDX_SAT);
  end

  // Next state: shift on each accepted pixel
  always_comb begin
    pix_d = pix_q;
    flg_d = flg_q;
    idx_d = idx_q;
    if (adv_i) begin
      pix_d[0] = pix_i;
      for (int i = 1; i < PIX_DEPTH; i++) pix_d[i] = pix_q[i-1];
      flg_d[0] = flg_new;
      for (int i = 1; i < DIST; i++) flg_d[i] = flg_q[i-1];
      idx_d = idx_now;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_q <= '0;
      flg_q <= '0;
      idx_q <= '0;
    end else begin
      pix_q <= pix_d;
      flg_q <= flg_d;
      idx_q <= idx_d;
    end
  end

  // Right neighbour is in the same line only if no line end lies between
  always_comb begin
    rok_o = 1'b1;
    for (int i = 0; i < DIST; i++) begin
      if (flg_q[i].eol) rok_o = 1'b0;
    end
  end

  assign lft_o     = pix_q[PIX_DEPTH-1];
  assign ctr_o     = pix_q[DIST-1];
  assign rgt_o     = pix_i;
  assign ctr_vld_o = flg_q[DIST-1].vld;
  assign ctr_sol_o = flg_q[DIST-1].sol;
  assign ctr_eol_o = flg_q[DIST-1].eol;
  assign lok_o     = flg_q[DIST-1].lok;

endmodule

// File: rtl/bpr_detect.sv
module bpr_detect
  import bpr_pkg::*;
#(
  parameter int unsigned DW = 10,
  parameter int unsigned TW = 7
) (
  input  logic          en_i,
  input  logic [TW-1:0] thr_i,
  input  logic [DW-1:0] lft_i,
  input  logic [DW-1:0] ctr_i,
  input  logic [DW-1:0] rgt_i,
  input  logic          lok_i,
  input  logic          rok_i,
  output logic [DW-1:0] pix_o
);

  localparam int unsigned EW = DW + 1;

  logic [EW-1:0] lx, cx, rx, tx;
  logic [EW-1:0] l_hi, r_hi, c_hi;
  logic [EW-1:0] sum_lr;
  logic          above, below;
  bpr_dec_e      dec;

  always_comb begin
    lx     = {1'b0, lft_i};
    cx     = {1'b0, ctr_i};
    rx     = {1'b0, rgt_i};
    tx     = EW'(thr_i);
    l_hi   = lx + tx;
    r_hi   = rx + tx;
    c_hi   = cx + tx;
    sum_lr = lx + rx;
    above  = (cx > l_hi) && (cx > r_hi);
    below  = (c_hi < lx) && (c_hi < rx);
  end

  always_comb begin
    if (!en_i || !lok_i || !rok_i) dec = DEC_EDGE;
    else if (above)                dec = DEC_HIGH;
    else if (below)                dec = DEC_LOW;
    else                           dec = DEC_KEEP;
  end

  always_comb begin
    case (dec)
      DEC_HIGH, DEC_LOW: pix_o = sum_lr[DW:1];
      default:           pix_o = ctr_i;
    endcase
  end

endmodule

// File: rtl/bpr_outstage.sv
module bpr_outstage #(
  parameter int unsigned DW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] pix_i,
  input  logic          sol_i,
  input  logic          eol_i,
  output logic          vld_o,
  output logic [DW-1:0] pix_o,
  output logic          sol_o,
  output logic          eol_o
);

  logic          vld_q, vld_d;
  logic [DW-1:0] pix_q, pix_d;
  logic          sol_q, sol_d;
  logic          eol_q, eol_d;

  always_comb begin
    vld_d = load_i;
    pix_d = pix_q;
    sol_d = sol_q;
    eol_d = eol_q;
    if (load_i) begin
      pix_d = pix_i;
      sol_d = sol_i;
      eol_d = eol_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      pix_q <= '0;
      sol_q <= 1'b0;
      eol_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      pix_q <= pix_d;
      sol_q <= sol_d;
      eol_q <= eol_d;
    end
  end

  assign vld_o = vld_q;
  assign pix_o = pix_q;
  assign sol_o = sol_q;
  assign eol_o = eol_q;

endmodule

// File: rtl/bpr_filter.sv
module bpr_filter #(
  parameter int unsigned DATA_W   = 10,
  parameter int unsigned THR_W    = 7,
  parameter int unsigned NBR_DIST = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              px_valid_i,
  input  logic [DATA_W-1:0] px_data_i,
  input  logic              px_sol_i,
  input  logic              px_eol_i,
  input  logic              flt_en_i,
  input  logic [THR_W-1:0]  flt_thr_i,
  output logic              px_valid_o,
  output logic [DATA_W-1:0] px_data_o,
  output logic              px_sol_o,
  output logic              px_eol_o
);

  logic [DATA_W-1:0] win_lft, win_ctr, win_rgt;
  logic              win_vld, win_sol, win_eol, win_lok, win_rok;
  logic [DATA_W-1:0] det_pix;
  logic              out_load;

  bpr_window #(
    .DW   (DATA_W),
    .DIST (NBR_DIST)
  ) u_window (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .adv_i     (px_valid_i),
    .pix_i     (px_data_i),
    .sol_i     (px_sol_i),
    .eol_i     (px_eol_i),
    .lft_o     (win_lft),
    .ctr_o     (win_ctr),
    .rgt_o     (win_rgt),
    .ctr_vld_o (win_vld),
    .ctr_sol_o (win_sol),
    .ctr_eol_o (win_eol),
    .lok_o     (win_lok),
    .rok_o     (win_rok)
  );

  bpr_detect #(
    .DW (DATA_W),
    .TW (THR_W)
  ) u_detect (
    .en_i  (flt_en_i),
    .thr_i (flt_thr_i),
    .lft_i (win_lft),
    .ctr_i (win_ctr),
    .rgt_i (win_rgt),
    .lok_i (win_lok),
    .rok_i (win_rok),
    .pix_o (det_pix)
  );

  AST_PASS_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flt_en_i |-> det_pix == win_ctr); // R1
  AST_EDGE_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(win_lok && win_rok) |-> det_pix == win_ctr); // R6
  AST_FIX_BETWEEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    det_pix != win_ctr |-> ((det_pix >= win_lft && det_pix <= win_rgt) ||
                            (det_pix >= win_rgt && det_pix <= win_lft))); // R2

  assign out_load = px_valid_i && win_vld;

  bpr_outstage #(
    .DW (DATA_W)
  ) u_outstage (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (out_load),
    .pix_i  (det_pix),
    .sol_i  (win_sol),
    .eol_i  (win_eol),
    .vld_o  (px_valid_o),
    .pix_o  (px_data_o),
    .sol_o  (px_sol_o),
    .eol_o  (px_eol_o)
  );

  AST_STALL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !px_valid_i |=> (!px_valid_o && $stable(px_data_o))); // R8
  AST_OUT_NEEDS_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    px_valid_o |-> $past(px_valid_i)); // R7

endmodule

// File: tb/bpr_filter_bench.sv
`timescale 1ns/1ps
module bpr_filter_bench;

  localparam int CLK_PERIOD = 10;
  localparam int MAXP       = 8192;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       px_valid_i, px_sol_i, px_eol_i, flt_en_i;
  logic [9:0] px_data_i;
  logic [6:0] flt_thr_i;
  logic       px_valid_o, px_sol_o, px_eol_o;
  logic [9:0] px_data_o;

  bpr_filter u_bpr_filter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .px_valid_i (px_valid_i),
    .px_data_i  (px_data_i),
    .px_sol_i   (px_sol_i),
    .px_eol_i   (px_eol_i),
    .flt_en_i   (flt_en_i),
    .flt_thr_i  (flt_thr_i),
    .px_valid_o (px_valid_o),
    .px_data_o  (px_data_o),
    .px_sol_o   (px_sol_o),
    .px_eol_o   (px_eol_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int px_a [MAXP];
  int thr_a[MAXP];
  int pos_a[MAXP];
  bit sol_a[MAXP];
  bit eol_a[MAXP];
  bit en_a [MAXP];

  int nin = 0, nout = 0, acc = 0;
  int ntot = 0, nfail = 0;
  bit cur_en = 1'b1;
  int cur_thr = 20;
  bit run = 1'b0, done = 1'b0, seen = 1'b0, prev_in = 1'b0;
  int last_pix = 0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    ntot++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Reference: result for stream pixel j, using config sent with pixel j+2
  function automatic int model(int j, output string tag);
    int l, c, r, t;
    bit lok, rok, hi, lo;
    string pre;
    c   = px_a[j];
    t   = thr_a[j+2];
    lok = pos_a[j] >= 2;
    rok = !eol_a[j] && !eol_a[j+1];
    if (!en_a[j+2]) begin tag = "R1"; return c; end
    if (!(lok && rok)) begin tag = "R6"; return c; end
    l  = px_a[j-2];
    r  = px_a[j+2];
    hi = (c > l + t) && (c > r + t);
    lo = (c + t < l) && (c + t < r);
    pre = (t == 0 || t == 127) ? "R9," : "";
    if (hi) begin tag = {pre, "R2"}; return (l + r) / 2; end
    if (lo) begin tag = {pre, "R3"}; return (l + r) / 2; end
    tag = {pre, "R4,R5"};
    return c;
  endfunction

  task automatic push(int v, bit s, bit e, int gap);
    px_a[nin]  = v;
    sol_a[nin] = s;
    eol_a[nin] = e;
    en_a[nin]  = cur_en;
    thr_a[nin] = cur_thr;
    pos_a[nin] = s ? 0 : ((nin == 0) ? 1 : pos_a[nin-1] + 1);
    nin++;
    px_valid_i = 1'b1;
    px_data_i  = 10'(v);
    px_sol_i   = s;
    px_eol_i   = e;
    flt_en_i   = cur_en;
    flt_thr_i  = 7'(cur_thr);
    @(posedge clk_i); #1;
    px_valid_i = 1'b0;
    repeat (gap) begin @(posedge clk_i); #1; end
  endtask

  task automatic send_line(int n, int vals[64]);
    for (int i = 0; i < n; i++) push(vals[i], i == 0, i == n - 1, 0);
  endtask

  // Monitor away from the active edge
  always @(negedge clk_i) begin
    if (run) begin
      if (prev_in) acc++;
      if (px_valid_o) begin
        string tag;
        int exp;
        exp = model(nout, tag);
        chk(px_data_o == 10'(exp), tag, "pixel", int'(px_data_o), exp);
        chk(acc == nout + 3, "R7", "accepted inputs at output", acc, nout + 3);
        chk({px_sol_o, px_eol_o} == {sol_a[nout], eol_a[nout]}, "R7", "markers",
            int'({px_sol_o, px_eol_o}), int'({sol_a[nout], eol_a[nout]}));
        last_pix = int'(px_data_o);
        seen = 1'b1;
        nout++;
      end else if (seen) begin
        chk(int'(px_data_o) == last_pix, "R8", "held output in idle", int'(px_data_o), last_pix);
      end
      prev_in = px_valid_i;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      ntot++; nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", ntot - nfail, ntot);
      $finish;
    end
  end

  initial begin
    int v[64];
    void'($urandom(32'd1234));
    px_valid_i = 0; px_data_i = 0; px_sol_i = 0; px_eol_i = 0;
    flt_en_i = 1; flt_thr_i = 7'd20;
    rst_ni = 1'b0;
    repeat (4) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    chk(px_valid_o == 1'b0, "R10", "valid after reset", int'(px_valid_o), 0);
    chk(px_data_o == 10'd0, "R10", "data after reset", int'(px_data_o), 0);
    @(posedge clk_i); #1;
    run = 1'b1;

    // Directed: flat colours with outliers at threshold boundaries
    cur_en = 1; cur_thr = 20;
    v = '{default: 0};
    for (int i = 0; i < 14; i++) v[i] = (i % 2) ? 600 : 100;
    v[0] = 1000; v[4] = 121; v[6] = 120; v[8] = 79; v[13] = 0; v[7] = 1023;
    send_line(14, v);
    // Mixed sides and other-colour spikes only
    for (int i = 0; i < 12; i++) v[i] = (i % 2) ? 900 : 300;
    v[2] = 200; v[4] = 400; v[5] = 0; v[7] = 1023;
    send_line(12, v);
    // Threshold extremes
    cur_thr = 0;
    for (int i = 0; i < 10; i++) v[i] = 500;
    v[4] = 501; v[6] = 499;
    send_line(10, v);
    cur_thr = 127;
    for (int i = 0; i < 10; i++) v[i] = 100;
    v[3] = 227; v[5] = 228; v[7] = 0;
    send_line(10, v);
    // Disabled with a clear outlier
    cur_en = 0; cur_thr = 5;
    for (int i = 0; i < 8; i++) v[i] = 50;
    v[4] = 900;
    send_line(8, v);

    // Random lines with gaps
    for (int ln = 0; ln < 120; ln++) begin
      int n, be, bo;
      n  = 1 + int'($urandom_range(0, 39));
      be = int'($urandom_range(0, 1023));
      bo = int'($urandom_range(0, 1023));
      cur_en  = ($urandom_range(0, 9) != 0);
      cur_thr = int'($urandom_range(0, 127));
      for (int i = 0; i < n; i++) begin
        int p;
        p = ((i % 2) ? bo : be) + int'($urandom_range(0, 16)) - 8;
        if ($urandom_range(0, 6) == 0) p = int'($urandom_range(0, 1023));
        if (p < 0) p = 0;
        if (p > 1023) p = 1023;
        push(p, i == 0, i == n - 1, int'($urandom_range(0, 2)));
      end
    end

    // Flush the last two pixels with a new line
    push(0, 1, 0, 0);
    push(0, 0, 0, 3);
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk(nout == nin - 2, "R7", "outputs delivered", nout, nin - 2);
    done = 1'b1;
    $display("%0d/%0d checks passed", ntot - nfail, ntot);
    $finish;
  end

endmodule